// File: doc/BRIEF.md
# Flow-Through Burst SRAM With No Bus Turnaround

A synchronous single-ported memory of parameterised depth and four byte lanes. Reads and writes may follow each other on every clock with no dead cycle between them. Each operation is a load cycle that registers a full address. It may be followed by advance cycles that step a 2-bit burst counter through the rest of an aligned group of four words.

Read data is flow-through. The word addressed at one rising edge comes out combinationally during the cycle that follows that edge. Write data lags its address by one edge: the address is registered at one edge and the data is captured at the next. The per-lane write strobes travel with the address, not with the data.

The block is meant as a small on-chip store or as a target for a memory controller under test. There is no stream back-pressure: the block takes a command on every enabled edge, and the `rdata_en` qualifier marks the cycles that carry read data. A held clock enable freezes every register, which stretches the previous cycle.

Top module: `nobubble_sram`

## Requirements
- R1: After reset the device is deselected. `rdata_en` is 0 and `rdata` is all zeros until a selecting load cycle occurs.
- R2: A load cycle (`adv`=0, `clk_en_n`=0) with `sel_a_n`=0, `sel_b_n`=0, `sel_c`=1 and `rd_not_wr`=1 makes `rdata` equal the stored word at `addr` during the following cycle, with `rdata_en`=1 while `oe_n`=0.
- R3: A write address registered at edge N takes its data from `wdata` at the next enabled edge. `byte_we_n[i]`=0, sampled together with that address, writes bits [8i+7:8i]; lanes whose strobe is 1 keep their old contents.
- R4: An advance cycle (`adv`=1) on an active operation adds 1 to the two low address bits, wrapping from 3 to 0, and leaves the upper bits unchanged. `rd_not_wr` and `addr` are ignored, and the read or write type of the operation is kept.
- R5: The chip selects are ignored on advance cycles. Deasserting them mid-burst does not stop the burst.
- R6: A load cycle with any select inactive deselects the device: `rdata_en` goes to 0 and no write happens. Later advance cycles leave it deselected.
- R7: While `clk_en_n`=1, rising edges are ignored: no register changes, no write happens, and the read output holds.
- R8: `oe_n`=1 forces `rdata_en` and `rdata` to 0 at once, without a clock, and does not disturb internal state.
- R9: A write followed in the very next cycle by a read of the same address returns the new data. Read, write, read sequences need no idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the block |
| adv | input | 1 | 1 = advance the burst, 0 = load a new address |
| rd_not_wr | input | 1 | 1 = read, 0 = write; sampled on load cycles only |
| sel_a_n | input | 1 | Active-low select, sampled on load cycles |
| sel_b_n | input | 1 | Active-low select, sampled on load cycles |
| sel_c | input | 1 | Active-high select, sampled on load cycles |
| addr | input | AW | Word address (AW = log2 DEPTH) |
| byte_we_n | input | 4 | Active-low lane write strobes, sampled with the address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| wdata | input | 32 | Write data, one edge after its address |
| rdata | output | 32 | Flow-through read data, zero when not driving |
| rdata_en | output | 1 | High when `rdata` carries valid read data |

## Verification
A wrong burst counter or a wrong held address shows up on `rdata` in the very cycle after the faulty edge, because reads have no pipeline stage. Wrong strobe or data timing in the write path stays hidden until that word is read back. For that reason the bench writes every location and then reads each one back, so a misplaced or dropped lane appears on the first read of that address. A wrong select or clock-enable state shows at once as a wrong `rdata_en` level or as `rdata` changing during a freeze.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
  localparam int LANES      = 4;
  localparam int LANE_W     = 8;
  localparam int DATA_W     = LANES * LANE_W;
  localparam int BURST_BITS = 2;

  typedef struct packed {
    logic             active;
    logic             is_wr;
    logic [LANES-1:0] lane_we_n;
  } nbs_op_t;
endpackage

// File: rtl/nbs_ctrl.sv
module nbs_ctrl
  import nbs_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en_n,
  input  logic             adv,
  input  logic             rd_not_wr,
  input  logic             sel_ok,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] byte_we_n,
  output logic [AW-1:0]    st_addr,
  output nbs_op_t          st_op
);
  localparam int HI_W = AW - BURST_BITS;

  logic [BURST_BITS-1:0] burst_q;
  logic [HI_W-1:0]       base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_op   <= '0;
      burst_q <= '0;
      base_q  <= '0;
    end else if (!clk_en_n) begin
      st_op.lane_we_n <= byte_we_n;
      if (!adv) begin
        st_op.active <= sel_ok;
        st_op.is_wr  <= !rd_not_wr;
        base_q       <= addr[AW-1:BURST_BITS];
        burst_q      <= addr[BURST_BITS-1:0];
      end else if (st_op.active) begin
        burst_q <= burst_q + 1'b1;
      end
    end
  end

  assign st_addr = {base_q, burst_q};
endmodule

// File: rtl/nbs_mem.sv
module nbs_mem
  import nbs_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic              clk,
  input  logic [LANES-1:0]  lane_we,
  input  logic [AW-1:0]     word_addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_we[g]) cells[word_addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = cells[word_addr];
  end
endmodule

// File: rtl/nobubble_sram.sv
module nobubble_sram
  import nbs_pkg::*;
#(
  parameter  int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              adv,
  input  logic              rd_not_wr,
  input  logic              sel_a_n,
  input  logic              sel_b_n,
  input  logic              sel_c,
  input  logic [AW-1:0]     addr,
  input  logic [LANES-1:0]  byte_we_n,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_en
);
  logic              sel_ok;
  logic [AW-1:0]     st_addr;
  nbs_op_t           st_op;
  logic [LANES-1:0]  lane_we;
  logic [DATA_W-1:0] mem_q;
  logic              wr_go;

  assign sel_ok = !sel_a_n && !sel_b_n && sel_c;

  nbs_ctrl #(.AW(AW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en_n  (clk_en_n),
    .adv       (adv),
    .rd_not_wr (rd_not_wr),
    .sel_ok    (sel_ok),
    .addr      (addr),
    .byte_we_n (byte_we_n),
    .st_addr   (st_addr),
    .st_op     (st_op)
  );

  // Data of a write is taken one enabled edge after its address.
  assign wr_go   = !clk_en_n && st_op.active && st_op.is_wr;
  assign lane_we = {LANES{wr_go}} & ~st_op.lane_we_n;

  nbs_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk       (clk),
    .lane_we   (lane_we),
    .word_addr (st_addr),
    .wdata     (wdata),
    .rdata     (mem_q)
  );

  assign rdata_en = st_op.active && !st_op.is_wr && !oe_n;
  assign rdata    = rdata_en ? mem_q : '0;
endmodule

// File: rtl/nobubble_sram_chk.sv
module nobubble_sram_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_en_n,
  input logic          adv,
  input logic          sel_a_n,
  input logic          sel_b_n,
  input logic          sel_c,
  input logic          oe_n,
  input logic [AW-1:0] addr,
  input logic [AW-1:0] st_addr,
  input logic          st_active,
  input logic          st_wr,
  input logic          rdata_en,
  input logic [31:0]   rdata
);
  p_load_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !adv) |=> st_addr == $past(addr));

  p_burst_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && adv && st_active) |=>
      (st_addr[1:0] == $past(st_addr[1:0]) + 2'd1) &&
      (st_addr[AW-1:2] == $past(st_addr[AW-1:2])));

  p_op_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && adv) |=> $stable(st_wr) && $stable(st_active));

  p_idle_stays_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && adv && !st_active) |=> !st_active);

  p_desel_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !adv && (sel_a_n || sel_b_n || !sel_c)) |=> !st_active && !rdata_en);

  p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> $stable(st_addr) && $stable(st_active) && $stable(st_wr));

  p_oe_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rdata_en && (rdata == 32'd0));
endmodule

bind nobubble_sram nobubble_sram_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clk_en_n  (clk_en_n),
  .adv       (adv),
  .sel_a_n   (sel_a_n),
  .sel_b_n   (sel_b_n),
  .sel_c     (sel_c),
  .oe_n      (oe_n),
  .addr      (addr),
  .st_addr   (st_addr),
  .st_active (st_op.active),
  .st_wr     (st_op.is_wr),
  .rdata_en  (rdata_en),
  .rdata     (rdata)
);

// File: tb/nobubble_sram_test.sv
module nobubble_sram_test;
  localparam int DEPTH = 64;
  localparam int AW    = 6;
  localparam logic [2:0] ON    = 3'b001;
  localparam logic [2:0] OFF_A = 3'b101;
  localparam logic [2:0] OFF_B = 3'b011;
  localparam logic [2:0] OFF_C = 3'b000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_en_n = 1'b0, adv = 1'b0, rd_not_wr = 1'b1;
  logic sel_a_n = 1'b1, sel_b_n = 1'b1, sel_c = 1'b0, oe_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [3:0]    byte_we_n = 4'hF;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          rdata_en;

  int   vectors = 0;
  int   fails = 0;
  bit   done = 1'b0;
  logic [31:0] exp_mem [DEPTH];

  always #5 clk = ~clk;

  nobubble_sram #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .adv(adv),
    .rd_not_wr(rd_not_wr), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n),
    .sel_c(sel_c), .addr(addr), .byte_we_n(byte_we_n), .oe_n(oe_n),
    .wdata(wdata), .rdata(rdata), .rdata_en(rdata_en)
  );

  function automatic logic [31:0] pat(input int a);
    logic [7:0] b = 8'(a);
    return {b ^ 8'h5A, ~b, b + 8'h33, 8'hC0 ^ 8'(a * 3)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic a_adv, input logic rnw, input int a,
                       input logic [3:0] ben, input logic [2:0] sel,
                       input logic [31:0] wd);
    adv = a_adv; rd_not_wr = rnw; addr = AW'(a); byte_we_n = ben;
    {sel_a_n, sel_b_n, sel_c} = sel; wdata = wd;
    @(posedge clk); #2;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    check("R1 rdata_en", 32'(rdata_en), 32'd0);
    check("R1 rdata", rdata, 32'd0);

    // R3 / R9: back-to-back writes of every word, data one cycle late
    for (int i = 0; i < DEPTH; i++) begin
      drive(1'b0, 1'b0, i, 4'h0, ON, (i == 0) ? 32'd0 : pat(i - 1));
      exp_mem[i] = pat(i);
    end
    drive(1'b0, 1'b1, 0, 4'hF, OFF_A, pat(DEPTH - 1));

    // R2: read back every word
    for (int i = 0; i < DEPTH; i++) begin
      drive(1'b0, 1'b1, i, 4'hF, ON, 32'd0);
      check("R2 read", rdata, exp_mem[i]);
      check("R2 rdata_en", 32'(rdata_en), 32'd1);
    end

    // R3: lanes 0 and 2 written (strobe bit low), lanes 1 and 3 kept
    drive(1'b0, 1'b0, 5, 4'b1010, ON, 32'd0);
    drive(1'b0, 1'b1, 0, 4'hF, OFF_B, 32'h11223344);
    exp_mem[5] = (exp_mem[5] & 32'hFF00FF00) | 32'h00220044;
    drive(1'b0, 1'b1, 5, 4'hF, ON, 32'd0);
    check("R3 lanes", rdata, exp_mem[5]);

    // R4 / R5: burst read from 6 wraps 6,7,4,5,6; rd_not_wr, addr, selects ignored
    drive(1'b0, 1'b1, 6, 4'hF, ON, 32'd0);
    check("R4 burst beat0", rdata, exp_mem[6]);
    for (int k = 1; k < 5; k++) begin
      drive(1'b1, 1'b0, 63, 4'hF, OFF_C, 32'd0);
      check("R4 R5 burst beat", rdata, exp_mem[4 + ((2 + k) % 4)]);
      check("R5 still driving", 32'(rdata_en), 32'd1);
    end

    // R4 / R3: burst write from 11 -> 11,8,9,10 with a per-beat strobe
    drive(1'b0, 1'b0, 11, 4'h0, ON, 32'd0);
    drive(1'b1, 1'b1, 0, 4'h0, ON, 32'hA0A0A0A0);
    drive(1'b1, 1'b1, 0, 4'b0111, OFF_A, 32'hB1B1B1B1);
    drive(1'b1, 1'b1, 0, 4'h0, ON, 32'hC2C2C2C2);
    drive(1'b0, 1'b1, 0, 4'hF, OFF_A, 32'hD3D3D3D3);
    exp_mem[11] = 32'hA0A0A0A0;
    exp_mem[8]  = 32'hB1B1B1B1;
    exp_mem[9]  = (exp_mem[9] & 32'h00FFFFFF) | 32'hC2000000;
    exp_mem[10] = 32'hD3D3D3D3;
    drive(1'b0, 1'b1, 8, 4'hF, ON, 32'd0);
    check("R4 wburst 8", rdata, exp_mem[8]);
    for (int k = 9; k < 12; k++) begin
      drive(1'b1, 1'b0, 0, 4'h0, ON, 32'hFFFFFFFF);
      check("R4 wburst", rdata, exp_mem[k]);
    end

    // R6: each select alone deselects; advance keeps it deselected
    drive(1'b0, 1'b1, 3, 4'hF, OFF_A, 32'd0);
    check("R6 sel_a", {rdata[30:0], rdata_en}, 32'd0);
    drive(1'b1, 1'b1, 3, 4'hF, ON, 32'd0);
    check("R6 adv after desel", {rdata[30:0], rdata_en}, 32'd0);
    drive(1'b0, 1'b1, 3, 4'hF, OFF_B, 32'd0);
    check("R6 sel_b", 32'(rdata_en), 32'd0);
    drive(1'b0, 0, 20, 4'h0, OFF_C, 32'd0);
    drive(1'b0, 1'b1, 20, 4'hF, ON, 32'hDEADBEEF);
    check("R6 no write when deselected", rdata, exp_mem[20]);
    drive(1'b0, 1'b0, 21, 4'h0, OFF_B, 32'd0);
    drive(1'b1, 1'b0, 0, 4'h0, ON, 32'h12345678);
    drive(1'b0, 1'b1, 21, 4'hF, ON, 32'h87654321);
    check("R6 adv write deselected", rdata, exp_mem[21]);

    // R7: freeze holds read output and defers a write
    drive(1'b0, 1'b1, 30, 4'hF, ON, 32'd0);
    clk_en_n = 1'b1;
    drive(1'b0, 1'b1, 31, 4'hF, ON, 32'd0);
    check("R7 hold read", rdata, exp_mem[30]);
    drive(1'b0, 1'b0, 31, 4'h0, OFF_C, 32'd0);
    check("R7 hold enable", 32'(rdata_en), 32'd1);
    clk_en_n = 1'b0;
    drive(1'b0, 1'b0, 32, 4'h0, ON, 32'd0);
    clk_en_n = 1'b1;
    drive(1'b0, 1'b1, 33, 4'hF, ON, 32'hBAD0BAD0);
    clk_en_n = 1'b0;
    drive(1'b0, 1'b1, 32, 4'hF, ON, 32'h600DF00D);
    exp_mem[32] = 32'h600DF00D;
    check("R7 deferred write", rdata, exp_mem[32]);

    // R8: asynchronous output gate
    drive(1'b0, 1'b1, 40, 4'hF, ON, 32'd0);
    oe_n = 1'b1; #1;
    check("R8 gated data", rdata, 32'd0);
    check("R8 gated enable", 32'(rdata_en), 32'd0);
    oe_n = 1'b0; #1;
    check("R8 restored", rdata, exp_mem[40]);

    // R9: write then immediate read; read-write-read without idles
    drive(1'b0, 1'b0, 45, 4'h0, ON, 32'd0);
    drive(1'b0, 1'b1, 45, 4'hF, ON, 32'h0BADCAFE);
    check("R9 write-then-read", rdata, 32'h0BADCAFE);
    drive(1'b0, 1'b1, 46, 4'hF, ON, 32'd0);
    check("R9 first read", rdata, exp_mem[46]);
    drive(1'b0, 1'b0, 47, 4'h0, ON, 32'd0);
    check("R9 write cycle quiet", 32'(rdata_en), 32'd0);
    drive(1'b0, 1'b1, 47, 4'hF, ON, 32'h13579BDF);
    check("R9 second read", rdata, 32'h13579BDF);
    check("R9 second enable", 32'(rdata_en), 32'd1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule